// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is a synchronous memory of 4,608 bits with one write port and one read port on a single clock. Each port picks its own data width from five organizations: 4k×1, 2k×2, 1k×4, 512×9 and 256×18. Data stored through one width can be fetched through another. For example, nibbles written four bits at a time can be streamed back one bit at a time.

The storage is 256 physical words of 18 bits. Each word holds two 9-bit lanes. The ninth bit of each lane exists only for the 9- and 18-bit organizations, so the three narrow organizations reach 4,096 bits. A narrow address splits into a word index and a sub-word position. Lower positions map to less significant bits.

Port widths are configuration inputs. They are captured only while reset is held. Reads are registered, with one clock of latency.

Top module: `mwdp_ram`

## Requirements
- R1: In the 18-bit organization (code 4), address bits [7:0] select one of 256 words and all 18 bits are written and read back unchanged.
- R2: In the 9-bit organization (code 3), address bits [8:1] select the word and bit 0 selects the lane. Lane 0 is word bits [8:0] and lane 1 is word bits [17:9].
- R3: In the 1-, 2- and 4-bit organizations (codes 0, 1, 2), only word bits 0–7 and 9–16 are reachable, packed in that order as positions 0–15. Position p = (address mod (16/w))·w + j holds data bit j. The word is address / (16/w). Bits 8 and 17 of every word are never changed by these writes.
- R4: Data written at one width is read at another through the same bit layout. A nibble written at 4-bit address n appears at 1-bit addresses 4n to 4n+3, least significant bit first. Sixteen single bits group into four nibbles in the same way.
- R5: Read-data bits at or above the read width are zero. Write-data bits at or above the write width are ignored. Address bits above the ones an organization needs are ignored.
- R6: Read data appears on the first clock edge after the read enable and address are sampled. It holds while the read enable is low, even if the word is written meanwhile.
- R7: When a write and a read address the same location in one cycle, the read returns the contents from before the write.
- R8: The width codes are 0 for ×1, 1 for ×2, 2 for ×4, 3 for ×9 and 4 for ×18. Codes 5–7 act as ×1. Each code is captured only while reset is high, and changing it afterwards has no effect.
- R9: Reset clears the read output to zero without altering the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset; captures width codes |
| wr_cfg | input | 3 | Write-port width code |
| rd_cfg | input | 3 | Read-port width code |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write address in units of the write width |
| wr_data | input | 18 | Write data, right-aligned |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read address in units of the read width |
| rd_data | output | 18 | Registered read data, right-aligned, zero-filled |

## Verification
A write and a read can land on the same physical word in the same cycle. The bench provokes this by raising both strobes on one address. It expects the value from before the write on the next cycle, and the new value from a follow-up read. A write that arrives while the read strobe is low is also checked: the registered output must keep its earlier value until a fresh read is issued.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;
    localparam int unsigned LANE_W = 9;
    localparam int unsigned LANES  = 2;
    localparam int unsigned WORD_W = LANE_W * LANES;
    localparam int unsigned PACK_W = (LANE_W - 1) * LANES;
    localparam int unsigned SUB_W  = $clog2(PACK_W);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        PW_X1  = 3'd0,
        PW_X2  = 3'd1,
        PW_X4  = 3'd2,
        PW_X9  = 3'd3,
        PW_X18 = 3'd4
    } pwidth_e;

    typedef struct packed {
        pwidth_e              mode;
        logic [SUB_W-1:0]     sub;
    } lane_sel_t;

    function automatic pwidth_e decode_width(input logic [2:0] code);
        case (code)
            3'd1:    return PW_X2;
            3'd2:    return PW_X4;
            3'd3:    return PW_X9;
            3'd4:    return PW_X18;
            default: return PW_X1;
        endcase
    endfunction

    // number of low address bits that pick a position inside a word
    function automatic int unsigned sub_bits(input pwidth_e m);
        case (m)
            PW_X2:   return SUB_W - 1;
            PW_X4:   return SUB_W - 2;
            PW_X9:   return $clog2(LANES);
            PW_X18:  return 0;
            default: return SUB_W;
        endcase
    endfunction

    function automatic int unsigned width_bits(input pwidth_e m);
        case (m)
            PW_X2:   return 2;
            PW_X4:   return 4;
            PW_X9:   return LANE_W;
            PW_X18:  return WORD_W;
            default: return 1;
        endcase
    endfunction

    // log2 of width for the packed (narrow) organizations
    function automatic int unsigned narrow_lg(input pwidth_e m);
        return SUB_W - sub_bits(m);
    endfunction

    // packed position -> physical bit, skipping each lane's ninth bit
    function automatic int unsigned phys_bit(input int unsigned c);
        return c + c / (LANE_W - 1);
    endfunction
endpackage

// File: rtl/mwdp_addr_split.sv
module mwdp_addr_split
    import mwdp_pkg::*;
#(
    parameter  int unsigned WA = 8,
    localparam int unsigned AW = WA + SUB_W
) (
    input  pwidth_e          mode,
    input  logic [AW-1:0]    addr,
    output logic [WA-1:0]    word,
    output logic [SUB_W-1:0] sub
);
    int unsigned   sb;
    logic [AW-1:0] low_mask;

    always_comb begin
        sb       = sub_bits(mode);
        low_mask = (AW'(1) << sb) - AW'(1);
        word     = WA'(addr >> sb);
        sub      = SUB_W'(addr & low_mask);
    end
endmodule

// File: rtl/mwdp_wr_map.sv
module mwdp_wr_map
    import mwdp_pkg::*;
(
    input  pwidth_e          mode,
    input  logic [SUB_W-1:0] sub,
    input  word_t            data,
    output word_t            mask,
    output word_t            bits
);
    for (genvar B = 0; B < WORD_W; B++) begin : g_bit
        localparam int unsigned LANE  = B / LANE_W;
        localparam int unsigned POS   = B % LANE_W;
        localparam bit          NINTH = (POS == LANE_W - 1);
        localparam int unsigned C     = LANE * (LANE_W - 1) + POS;

        always_comb begin
            int unsigned lg;
            logic [4:0]  di;
            lg = narrow_lg(mode);
            di = 5'(C & ((32'd1 << lg) - 32'd1));
            mask[B] = 1'b0;
            bits[B] = 1'b0;
            case (mode)
                PW_X18: begin
                    mask[B] = 1'b1;
                    bits[B] = data[B];
                end
                PW_X9: begin
                    mask[B] = (32'(sub) == LANE);
                    bits[B] = data[POS];
                end
                default: begin
                    if (!NINTH) begin
                        mask[B] = ((C >> lg) == 32'(sub));
                        bits[B] = data[di];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mwdp_rd_extract.sv
module mwdp_rd_extract
    import mwdp_pkg::*;
(
    input  word_t     word,
    input  lane_sel_t sel,
    output word_t     data
);
    for (genvar J = 0; J < WORD_W; J++) begin : g_out
        always_comb begin
            int unsigned lg;
            int unsigned c;
            logic [4:0]  pi;
            lg      = narrow_lg(sel.mode);
            c       = (32'(sel.sub) << lg) + J;
            data[J] = 1'b0;
            case (sel.mode)
                PW_X18: data[J] = word[J];
                PW_X9: begin
                    if (J < LANE_W) begin
                        pi      = 5'(32'(sel.sub[0]) * LANE_W + J);
                        data[J] = word[pi];
                    end
                end
                default: begin
                    if (J < (32'd1 << lg)) begin
                        pi      = 5'(phys_bit(c));
                        data[J] = word[pi];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mwdp_array.sv
module mwdp_array
    import mwdp_pkg::*;
#(
    parameter  int unsigned WORDS = 256,
    localparam int unsigned WA    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [WA-1:0] waddr,
    input  word_t         wmask,
    input  word_t         wbits,
    input  logic          re,
    input  logic [WA-1:0] raddr,
    output word_t         rword
);
    word_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= (mem[waddr] & ~wmask) | (wbits & wmask);
    end

    always_ff @(posedge clk) begin
        if (rst)     rword <= '0;
        else if (re) rword <= mem[raddr];
    end
endmodule

// File: rtl/mwdp_ram.sv
module mwdp_ram
    import mwdp_pkg::*;
#(
    parameter  int unsigned WORDS = 256,
    localparam int unsigned WA    = $clog2(WORDS),
    localparam int unsigned AW    = WA + SUB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        wr_cfg,
    input  logic [2:0]        rd_cfg,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    pwidth_e          wr_mode_q;
    pwidth_e          rd_mode_q;
    logic [WA-1:0]    wr_word;
    logic [SUB_W-1:0] wr_sub;
    logic [WA-1:0]    rd_word;
    logic [SUB_W-1:0] rd_sub;
    word_t            wr_mask;
    word_t            wr_bits;
    word_t            rd_raw;
    lane_sel_t        rd_sel_q;

    // width codes are captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_mode_q <= decode_width(wr_cfg);
            rd_mode_q <= decode_width(rd_cfg);
        end
    end

    mwdp_addr_split #(.WA(WA)) wr_split_i (
        .mode(wr_mode_q), .addr(wr_addr), .word(wr_word), .sub(wr_sub)
    );

    mwdp_addr_split #(.WA(WA)) rd_split_i (
        .mode(rd_mode_q), .addr(rd_addr), .word(rd_word), .sub(rd_sub)
    );

    mwdp_wr_map wr_map_i (
        .mode(wr_mode_q), .sub(wr_sub), .data(wr_data),
        .mask(wr_mask), .bits(wr_bits)
    );

    mwdp_array #(.WORDS(WORDS)) array_i (
        .clk(clk), .rst(rst),
        .we(wr_en & ~rst), .waddr(wr_word), .wmask(wr_mask), .wbits(wr_bits),
        .re(rd_en & ~rst), .raddr(rd_word), .rword(rd_raw)
    );

    // lane selection travels alongside the registered word
    always_ff @(posedge clk) begin
        if (rst)        rd_sel_q <= '{mode: PW_X1, sub: '0};
        else if (rd_en) rd_sel_q <= '{mode: rd_mode_q, sub: rd_sub};
    end

    mwdp_rd_extract rd_ext_i (
        .word(rd_raw), .sel(rd_sel_q), .data(rd_data)
    );
endmodule

// File: rtl/mwdp_ram_chk.sv
module mwdp_ram_chk
    import mwdp_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_en,
    input logic  rd_en,
    input word_t rd_data,
    input word_t wr_mask,
    input pwidth_e wr_mode,
    input pwidth_e rd_mode
);
    // R3: a write touches exactly as many bits as its port width
    a_r3_mask_width: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(wr_mask) == width_bits(wr_mode)));

    // R5: bits above the read width stay zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((rd_data >> width_bits(rd_mode)) == '0));

    // R6: an idle read port holds its output
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R8: captured widths do not move outside reset
    a_r8_cfg_static: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ($stable(wr_mode) && $stable(rd_mode)));
endmodule

bind mwdp_ram mwdp_ram_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .wr_mask(wr_mask), .wr_mode(wr_mode_q), .rd_mode(rd_mode_q)
);

// File: tb/mwdp_ram_tb_top.sv
`timescale 1ns/1ps
module mwdp_ram_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  wr_cfg = 3'd4;
    logic [2:0]  rd_cfg = 3'd4;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [17:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit ref_bits [4608];
    int cur_w = 4;
    int cur_r = 4;

    always #2 clk = ~clk;

    mwdp_ram dut_i (
        .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .rd_cfg(rd_cfg),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int wdt(int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 9;
            4: return 18;
            default: return 1;
        endcase
    endfunction

    // flat bit index of data bit j at an address, from R1-R3 layouts
    function automatic int flat_pos(int code, int addr, int j);
        int w, per, word, idx, c;
        w = wdt(code);
        if (w == 18) return (addr % 256) * 18 + j;
        if (w == 9)  return ((addr / 2) % 256) * 18 + (addr % 2) * 9 + j;
        per  = 16 / w;
        word = (addr / per) % 256;
        idx  = addr % per;
        c    = idx * w + j;
        return word * 18 + c + c / 8;
    endfunction

    function automatic logic [17:0] model_read(int code, int addr);
        logic [17:0] v;
        v = '0;
        for (int j = 0; j < wdt(code); j++) v[j] = ref_bits[flat_pos(code, addr, j)];
        return v;
    endfunction

    task automatic model_write(int code, int addr, logic [17:0] d);
        for (int j = 0; j < wdt(code); j++) ref_bits[flat_pos(code, addr, j)] = d[j];
    endtask

    function automatic logic [17:0] pat(int a, int salt);
        return 18'((a * 40503 + salt * 977) ^ (a << 7) ^ (salt << 13));
    endfunction

    task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic cfg(int w, int r);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        wr_cfg = 3'(w); rd_cfg = 3'(r);
        cur_w = w; cur_r = r;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 reset clears read output", rd_data, 18'h0);
    endtask

    task automatic do_wr(int addr, logic [17:0] d);
        wr_en = 1'b1; wr_addr = 12'(addr); wr_data = d;
        model_write(cur_w, addr, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(string tag, int addr);
        logic [17:0] exp;
        exp = model_read(cur_r, addr);
        rd_en = 1'b1; rd_addr = 12'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, rd_data, exp);
    endtask

    initial begin
        logic [17:0] held, old;
        cfg(4, 4);
        for (int a = 0; a < 256; a++) do_wr(a, pat(a, 1));
        for (int a = 0; a < 256; a++) do_rd("R1 x18 round trip", a);
        do_wr(12'hA07, pat(7, 2));
        do_rd("R5 upper address bits ignored", 12'h307);

        cfg(3, 3);
        for (int a = 0; a < 512; a++) do_wr(a, pat(a, 3));
        for (int a = 0; a < 512; a++) do_rd("R2 x9 lane round trip", a);
        cfg(3, 4);
        for (int a = 0; a < 256; a++) do_rd("R2 x9 lanes inside x18 word", a);

        cfg(2, 4);
        for (int a = 0; a < 1024; a++) do_wr(a, pat(a, 4));
        for (int a = 0; a < 256; a++) do_rd("R3 ninth bits untouched by x4", a);
        cfg(2, 0);
        for (int a = 0; a < 4096; a++) do_rd("R4 x4 data read serially at x1", a);

        cfg(1, 1);
        for (int a = 0; a < 2048; a++) do_wr(a, pat(a, 5));
        for (int a = 0; a < 2048; a++) do_rd("R3 x2 round trip", a);

        cfg(0, 2);
        for (int a = 0; a < 4096; a++) do_wr(a, pat(a, 6));
        for (int a = 0; a < 1024; a++) do_rd("R4 x1 bits gathered at x4", a);
        cfg(0, 4);
        for (int a = 0; a < 256; a++) do_rd("R3 ninth bits untouched by x1", a);

        // R6: idle read port holds across a write to the same word
        cfg(4, 4);
        do_rd("R6 read latency one cycle", 5);
        held = rd_data;
        rd_addr = 12'd9;
        do_wr(5, ~held);
        @(negedge clk);
        check("R6 output held while read idle", rd_data, held);
        do_rd("R6 fresh read sees new data", 5);

        // R7: same-cycle write and read of one location
        old = model_read(4, 20);
        wr_en = 1'b1; wr_addr = 12'd20; wr_data = pat(20, 9);
        rd_en = 1'b1; rd_addr = 12'd20;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R7 collision returns old data", rd_data, old);
        model_write(4, 20, pat(20, 9));
        do_rd("R7 follow-up read returns new data", 20);

        // R8: undefined code acts as x1; codes ignored outside reset
        cfg(4, 5);
        do_rd("R8 code 5 reads as x1", 50);
        rd_cfg = 3'd4;
        wr_cfg = 3'd3;
        do_rd("R8 read code change ignored after reset", 50);
        do_wr(33, pat(33, 11));
        for (int k = 0; k < 16; k++) do_rd("R8 write code change ignored after reset", 33 * 16 + k);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            finish_run();
        end
    end
endmodule